// File: doc/BRIEF.md
# Autobaud Low-Pulse Measurement Unit

This unit times a single low pulse on an asynchronous serial receive line, so that software can work out the line's bit rate from the result. Software arms a measurement by setting a start control bit. The unit then waits for the line to fall. It counts clock cycles for as long as the line stays low. When the line rises, it stores the count, returns to its ready state, clears the start bit by itself and, if enabled, raises an interrupt flag.

The receive line passes through a synchronizer before any edge is detected. The count register keeps showing the last finished result while a new measurement is running. The live counter stops at its largest value instead of wrapping.

A measurement cannot be cancelled once counting has begun. If software clears the start bit during counting, the unit stays in the counting state. It then flags an interrupt on every later rising edge. Setting the start bit again lets the next rising edge finish the measurement normally.

Top module: `abr_pulse_meter`

## Requirements
- R1: After reset the status is 0 (not initialised), and the count, start bit, interrupt enable and interrupt flag are all 0. The status only ever reads 0, 1 (ready) or 2 (counting).
- R2: A control write with the start bit or the interrupt-enable bit set moves the status from 0 to 1. A control write with both bits clear leaves the status at 0. The status never returns to 0.
- R3: When the status is 1 and the start bit is set, a falling edge on the receive line moves the status to 2.
- R4: A finished measurement equals the number of consecutive rising clock edges at which the receive input was sampled low.
- R5: While the status is 2, the count output keeps the previous finished result.
- R6: When the start bit is set and the rising edge ends a count, the status becomes 1, the start bit clears and the new count appears.
- R7: At the end of a count the interrupt flag is set only if the interrupt enable is 1. With the enable at 0 the flag stays clear.
- R8: Pulsing irq_ack clears the interrupt flag. A new event in the same cycle as irq_ack wins, so the flag stays set.
- R9: If the start bit is cleared while the status is 2, counting goes on. Every later rising edge sets the interrupt flag (when enabled), leaves the status at 2 and leaves the count output unchanged. Falling edges in this condition are ignored.
- R10: If the start bit is set again after the R9 case, the next rising edge finishes normally. It stores the live count, which has run since the original falling edge.
- R11: The live count saturates at 2^CNT_W-1, so a longer pulse reads as that maximum.
- R12: A falling edge while the start bit is 0 and the status is 1 starts nothing. The status stays 1, the count is unchanged and no interrupt is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| ctl_we | input | 1 | Control write strobe; loads ctl_start and ctl_irq_en |
| ctl_start | input | 1 | Start bit value to write |
| ctl_irq_en | input | 1 | Interrupt enable value to write |
| irq_ack | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| abr_status | output | 2 | 0 not initialised, 1 ready, 2 counting |
| abr_count | output | CNT_W | Last finished measurement |
| start_o | output | 1 | Current start bit |
| irq_en_o | output | 1 | Current interrupt enable |
| irq_pend_o | output | 1 | Interrupt flag |

## Verification
The bench builds the unit with CNT_W set to 6. This makes the saturation limit 63, so short pulses already reach the saturated reading, and a pulse one cycle longer than the limit exercises the limit directly. SYNC_STAGES keeps its default of 2, and expected counts are independent of that latency because both edges are delayed by the same amount. The narrow counter also means the live count saturates during the cancel-and-rearm sequence, which makes the recovered result a known value.

// File: rtl/abr_pkg.sv
package abr_pkg;

    typedef enum logic [1:0] {
        ST_NOINIT = 2'd0,
        ST_READY  = 2'd1,
        ST_COUNT  = 2'd2
    } abr_state_e;

    typedef struct packed {
        abr_state_e state;
        logic       start;
        logic       irq_en;
        logic       irq_pend;
    } abr_ctrl_s;

endpackage

// File: rtl/abr_edge_det.sv
module abr_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_s;

    edge_s edge_d, edge_q;

    // shift chain toward MSB; prev holds last synchronized level
    always_comb begin
        edge_d      = edge_q;
        edge_d.sync = {edge_q.sync[SYNC_STAGES-2:0], line_i};
        edge_d.prev = edge_q.sync[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_q <= '1;
        else        edge_q <= edge_d;
    end

    assign fall_o =  edge_q.prev & ~edge_q.sync[MSB];
    assign rise_o = ~edge_q.prev &  edge_q.sync[MSB];
endmodule

// File: rtl/abr_sat_counter.sv
module abr_sat_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         run_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CNT_ONE;
        else if (run_i && (cnt_q != CNT_MAX))
            cnt_d = cnt_q + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/abr_pulse_meter.sv
module abr_pulse_meter
    import abr_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             ctl_we,
    input  logic             ctl_start,
    input  logic             ctl_irq_en,
    input  logic             irq_ack,
    output logic [1:0]       abr_status,
    output logic [CNT_W-1:0] abr_count,
    output logic             start_o,
    output logic             irq_en_o,
    output logic             irq_pend_o
);
    logic             fall_w, rise_w;
    logic             load_w, run_w;
    logic [CNT_W-1:0] live_cnt;

    abr_ctrl_s        ctrl_d, ctrl_q;
    logic [CNT_W-1:0] res_d, res_q;
    logic             event_w;

    abr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_i),
        .fall_o (fall_w),
        .rise_o (rise_w)
    );

    abr_sat_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .run_i  (run_w),
        .cnt_o  (live_cnt)
    );

    always_comb begin
        ctrl_d  = ctrl_q;
        res_d   = res_q;
        load_w  = 1'b0;
        run_w   = (ctrl_q.state == ST_COUNT);
        event_w = 1'b0;

        unique case (ctrl_q.state)
            ST_NOINIT: begin
                if (ctl_we && (ctl_start || ctl_irq_en))
                    ctrl_d.state = ST_READY;
            end
            ST_READY: begin
                if (ctrl_q.start && fall_w) begin
                    ctrl_d.state = ST_COUNT;
                    load_w       = 1'b1;
                end
            end
            ST_COUNT: begin
                if (rise_w) begin
                    event_w = 1'b1;
                    // without start the count cannot stop: flag only
                    if (ctrl_q.start) begin
                        ctrl_d.state = ST_READY;
                        ctrl_d.start = 1'b0;
                        res_d        = live_cnt;
                    end
                end
            end
            default: ctrl_d.state = ST_NOINIT;
        endcase

        if (irq_ack)
            ctrl_d.irq_pend = 1'b0;
        if (event_w && ctrl_q.irq_en)
            ctrl_d.irq_pend = 1'b1;

        // a software write overrides the self-clear of the same cycle
        if (ctl_we) begin
            ctrl_d.start  = ctl_start;
            ctrl_d.irq_en = ctl_irq_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_NOINIT, start: 1'b0, irq_en: 1'b0, irq_pend: 1'b0};
            res_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            res_q  <= res_d;
        end
    end

    assign abr_status = ctrl_q.state;
    assign abr_count  = res_q;
    assign start_o    = ctrl_q.start;
    assign irq_en_o   = ctrl_q.irq_en;
    assign irq_pend_o = ctrl_q.irq_pend;
endmodule

// File: rtl/abr_pulse_meter_chk.sv
module abr_pulse_meter_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [1:0]       status,
    input logic [CNT_W-1:0] count,
    input logic             start,
    input logic             irq_en,
    input logic             irq_pend,
    input logic             rise,
    input logic [CNT_W-1:0] live
);
    localparam logic [CNT_W-1:0] LIVE_MAX = '1;

    assert_legal_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);

    assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd0) |=> (status != 2'd0));

    assert_prev_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2) |=> ((status != 2'd2) || $stable(count)));

    assert_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && start && rise && !ctl_we) |=> (status == 2'd1 && !start));

    assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pend && !irq_en) |=> !irq_pend);

    assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && !start && rise && irq_en) |=> (status == 2'd2 && irq_pend));

    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && live == LIVE_MAX) |=> ((status != 2'd2) || (live == LIVE_MAX)));
endmodule

bind abr_pulse_meter abr_pulse_meter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .status   (abr_status),
    .count    (abr_count),
    .start    (start_o),
    .irq_en   (irq_en_o),
    .irq_pend (irq_pend_o),
    .rise     (rise_w),
    .live     (live_cnt)
);

// File: tb/sim_abr_pulse_meter.sv
`timescale 1ns/1ps
module sim_abr_pulse_meter;
    localparam int CW = 6;
    localparam int NV = 6;
    // vectors: low width, irq enable, expected count, expected flag
    localparam int VW  [NV] = '{1, 5, 17, 63, 64, 150};
    localparam bit VEN [NV] = '{1, 0, 1, 1, 0, 1};
    localparam int VCNT[NV] = '{1, 5, 17, 63, 63, 63};
    localparam bit VIRQ[NV] = '{1, 0, 1, 1, 0, 1};

    logic clk = 0, rst_n = 0, rx = 1;
    logic ctl_we = 0, ctl_start = 0, ctl_irq_en = 0, irq_ack = 0;
    logic [1:0] st;
    logic [CW-1:0] cnt;
    logic start_o, en_o, irq;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    abr_pulse_meter #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .ctl_we(ctl_we),
        .ctl_start(ctl_start), .ctl_irq_en(ctl_irq_en), .irq_ack(irq_ack),
        .abr_status(st), .abr_count(cnt), .start_o(start_o),
        .irq_en_o(en_o), .irq_pend_o(irq)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit s, bit e);
        @(negedge clk); ctl_we = 1; ctl_start = s; ctl_irq_en = e;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    task automatic pulse(int n);
        @(negedge clk); rx = 0;
        repeat (n) @(negedge clk);
        rx = 1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 status", st, 0);
        check("R1 count", cnt, 0);
        check("R1 start", start_o, 0);
        check("R1 irq", irq, 0);

        wr(0, 0);
        check("R2 zero write keeps status", st, 0);
        wr(0, 1);
        check("R2 enable write readies", st, 1);
        wr(0, 0);
        check("R2 stays ready", st, 1);

        pulse(10);
        check("R12 status", st, 1);
        check("R12 count", cnt, 0);
        check("R12 irq", irq, 0);

        for (int i = 0; i < NV; i++) begin
            ack();
            wr(1, VEN[i]);
            check("R3 armed", start_o, 1);
            pulse(VW[i]);
            check("R4 R11 count", cnt, VCNT[i]);
            check("R6 status ready", st, 1);
            check("R6 start cleared", start_o, 0);
            check("R7 irq", irq, VIRQ[i]);
        end

        ack();
        check("R8 ack clears", irq, 0);
        wr(1, 1);
        @(negedge clk); rx = 0;
        repeat (10) @(negedge clk);
        check("R3 counting", st, 2);
        check("R5 previous count", cnt, 63);
        repeat (10) @(negedge clk);
        rx = 1;
        repeat (5) @(negedge clk);
        check("R4 mid count", cnt, 20);

        ack();
        wr(1, 1);
        @(negedge clk); rx = 0;
        repeat (10) @(negedge clk);
        wr(0, 1);
        rx = 1;
        repeat (5) @(negedge clk);
        check("R9 still counting", st, 2);
        check("R9 irq", irq, 1);
        check("R9 count held", cnt, 20);
        ack();
        pulse(40);
        check("R9 irq again", irq, 1);
        check("R9 status", st, 2);
        ack();
        wr(1, 1);
        pulse(40);
        check("R10 status", st, 1);
        check("R10 start", start_o, 0);
        check("R10 count", cnt, 63);
        check("R10 irq", irq, 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule